// File: doc/BRIEF.md
# Cache Maintenance Access Gate

This block stands between a maintenance port (a register or bus path used to inspect and patch a platform cache) and that cache's tag and data arrays. A single status input says whether any flash segment currently carries the execute-only attribute. While that bit is clear, the gate is transparent. Maintenance reads and writes reach either array unchanged.

While the bit is set, the gate hides the cache contents. Writes to either array are dropped. Tag reads still return the stored tag. Data reads return all zeros.

Every request is acknowledged one cycle later, whether it was carried out or dropped. No error is signalled. The arrays are expected to have a synchronous read: the index is presented in the request cycle, and the word appears on the array's read port on the next cycle. The gate samples the protection bit in the request cycle and holds that decision for the response.

Top module: `cache_view_gate`

## Requirements
- R1: With `anyXo` low, a write request with `reqSel`=0 (tag array) raises `tagWe` in the request cycle, with `arrIndex` equal to `reqIndex` and `tagWdata` equal to the low TAG_W bits of `reqWdata`. `dataWe` stays low.
- R2: With `anyXo` low, a write request with `reqSel`=1 (data array) raises `dataWe` in the request cycle, with `dataWdata` equal to `reqWdata`. `tagWe` stays low.
- R3: With `anyXo` low, a read request returns the addressed word on `rdData` one cycle later. A tag appears in the low TAG_W bits of `rdData`, and the upper bits are zero.
- R4: With `anyXo` high, a tag write keeps `tagWe` low, and the stored tag is left unchanged.
- R5: With `anyXo` high, a tag read still returns the stored tag, formatted as in R3.
- R6: With `anyXo` high, a data write keeps `dataWe` low, and the stored word is left unchanged.
- R7: With `anyXo` high, a data read returns all zeros on `rdData`.
- R8: `ackValid` is high exactly in the cycle after each request, including dropped writes. It is low after a cycle with no request.
- R9: The protection decision uses the value of `anyXo` in the request cycle. A change of `anyXo` in the response cycle does not alter `rdData`.
- R10: During and after reset, until the first request, `ackValid`, `tagWe`, `dataWe` and `rdData` are all zero. `rdData` is also zero in any cycle that does not answer a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSel | input | 1 | Array select: 0 = tag, 1 = data |
| reqIndex | input | IDX_W | Array index |
| reqWdata | input | DATA_W | Write data (tag uses low TAG_W bits) |
| anyXo | input | 1 | High while any segment is execute-only |
| tagRdata | input | TAG_W | Tag array read port (one cycle after index) |
| dataRdata | input | DATA_W | Data array read port (one cycle after index) |
| tagWe | output | 1 | Tag array write enable |
| dataWe | output | 1 | Data array write enable |
| arrIndex | output | IDX_W | Index toward both arrays |
| tagWdata | output | TAG_W | Tag array write data |
| dataWdata | output | DATA_W | Data array write data |
| ackValid | output | 1 | Response strobe, one cycle after a request |
| rdData | output | DATA_W | Read response |

## Verification
The bench builds the gate with IDX_W=4, TAG_W=12 and DATA_W=32. The 12-bit tag inside a 32-bit response checks that the upper response bits are zero on every tag read. The 16-entry arrays let the tests reach both the first and the last index. Dropped writes are then shown to be harmless by reading the same entry back with protection off. Protection is also toggled in the response cycle to show that the decision was latched in the request cycle.

// File: rtl/cvg_pkg.sv
package cvg_pkg;

  typedef enum logic {
    ARR_TAG  = 1'b0,
    ARR_DATA = 1'b1
  } arr_sel_e;

  typedef struct packed {
    logic tagWe;
    logic dataWe;
    logic respValid;
    logic respRead;
    logic respData;
    logic respZero;
  } gate_strobes_t;

endpackage

// File: rtl/cvg_ctrl.sv
module cvg_ctrl
  import cvg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          reqSel,
  input  logic          anyXo,
  output gate_strobes_t strb
);

  arr_sel_e sel;
  logic isWrite;
  logic isRead;
  logic ackQ;
  logic readQ;
  logic dataQ;
  logic zeroQ;

  always_comb begin
    sel     = arr_sel_e'(reqSel);
    isWrite = reqValid && reqWrite;
    isRead  = reqValid && !reqWrite;
  end

  // Decision latched with the request; the response cycle ignores anyXo.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ  <= 1'b0;
      readQ <= 1'b0;
      dataQ <= 1'b0;
      zeroQ <= 1'b0;
    end else begin
      ackQ  <= reqValid;
      readQ <= isRead;
      dataQ <= (sel == ARR_DATA);
      zeroQ <= anyXo && (sel == ARR_DATA);
    end
  end

  always_comb begin
    strb.tagWe     = isWrite && (sel == ARR_TAG)  && !anyXo;
    strb.dataWe    = isWrite && (sel == ARR_DATA) && !anyXo;
    strb.respValid = ackQ;
    strb.respRead  = readQ;
    strb.respData  = dataQ;
    strb.respZero  = zeroQ;
  end

endmodule

// File: rtl/cvg_datapath.sv
module cvg_datapath
  import cvg_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  gate_strobes_t     strb,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [TAG_W-1:0]  tagRdata,
  input  logic [DATA_W-1:0] dataRdata,
  output logic              tagWe,
  output logic              dataWe,
  output logic [IDX_W-1:0]  arrIndex,
  output logic [TAG_W-1:0]  tagWdata,
  output logic [DATA_W-1:0] dataWdata,
  output logic              ackValid,
  output logic [DATA_W-1:0] rdData
);

  always_comb begin
    tagWe     = strb.tagWe;
    dataWe    = strb.dataWe;
    arrIndex  = reqIndex;
    tagWdata  = reqWdata[TAG_W-1:0];
    dataWdata = reqWdata;
    ackValid  = strb.respValid;
  end

  always_comb begin
    rdData = '0;
    if (strb.respRead && !strb.respZero) begin
      if (strb.respData) rdData = dataRdata;
      else               rdData[TAG_W-1:0] = tagRdata;
    end
  end

endmodule

// File: rtl/cache_view_gate.sv
module cache_view_gate
  import cvg_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSel,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              anyXo,
  input  logic [TAG_W-1:0]  tagRdata,
  input  logic [DATA_W-1:0] dataRdata,
  output logic              tagWe,
  output logic              dataWe,
  output logic [IDX_W-1:0]  arrIndex,
  output logic [TAG_W-1:0]  tagWdata,
  output logic [DATA_W-1:0] dataWdata,
  output logic              ackValid,
  output logic [DATA_W-1:0] rdData
);

  gate_strobes_t strb;

  cvg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSel   (reqSel),
    .anyXo    (anyXo),
    .strb     (strb)
  );

  cvg_datapath #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .strb      (strb),
    .reqIndex  (reqIndex),
    .reqWdata  (reqWdata),
    .tagRdata  (tagRdata),
    .dataRdata (dataRdata),
    .tagWe     (tagWe),
    .dataWe    (dataWe),
    .arrIndex  (arrIndex),
    .tagWdata  (tagWdata),
    .dataWdata (dataWdata),
    .ackValid  (ackValid),
    .rdData    (rdData)
  );

endmodule

// File: rtl/cvg_checker.sv
module cvg_checker #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqSel,
  input logic [IDX_W-1:0]  reqIndex,
  input logic [DATA_W-1:0] reqWdata,
  input logic              anyXo,
  input logic [TAG_W-1:0]  tagRdata,
  input logic [DATA_W-1:0] dataRdata,
  input logic              tagWe,
  input logic              dataWe,
  input logic [IDX_W-1:0]  arrIndex,
  input logic [TAG_W-1:0]  tagWdata,
  input logic [DATA_W-1:0] dataWdata,
  input logic              ackValid,
  input logic [DATA_W-1:0] rdData
);

  p_tag_write_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqSel && !anyXo) |-> (tagWe && !dataWe && arrIndex == reqIndex));

  p_data_write_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSel && !anyXo) |-> (dataWe && !tagWe && dataWdata == reqWdata));

  p_tag_we_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyXo |-> !tagWe);

  p_tag_read_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqSel && anyXo) |=>
      (rdData[TAG_W-1:0] == tagRdata && (rdData >> TAG_W) == '0));

  p_data_we_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyXo |-> !dataWe);

  p_data_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSel && anyXo) |=> (rdData == '0));

  p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ackValid);

  p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !ackValid);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqWrite) |=> (rdData == '0));

endmodule

bind cache_view_gate cvg_checker #(
  .IDX_W  (IDX_W),
  .TAG_W  (TAG_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/cvg_array_model.sv
module cvg_array_model #(
  parameter int IDX_W = 4,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [2**IDX_W];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: tb/test_cache_view_gate.sv
module test_cache_view_gate;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = 12;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqWrite;
  logic              reqSel;
  logic [IDX_W-1:0]  reqIndex;
  logic [DATA_W-1:0] reqWdata;
  logic              anyXo;
  logic [TAG_W-1:0]  tagRdata;
  logic [DATA_W-1:0] dataRdata;
  logic              tagWe;
  logic              dataWe;
  logic [IDX_W-1:0]  arrIndex;
  logic [TAG_W-1:0]  tagWdata;
  logic [DATA_W-1:0] dataWdata;
  logic              ackValid;
  logic [DATA_W-1:0] rdData;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_view_gate #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_cache_view_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqSel(reqSel),
    .reqIndex(reqIndex), .reqWdata(reqWdata), .anyXo(anyXo), .tagRdata(tagRdata),
    .dataRdata(dataRdata), .tagWe(tagWe), .dataWe(dataWe), .arrIndex(arrIndex),
    .tagWdata(tagWdata), .dataWdata(dataWdata), .ackValid(ackValid), .rdData(rdData)
  );

  cvg_array_model #(.IDX_W(IDX_W), .W(TAG_W)) u_tagArr (
    .clk(clk), .we(tagWe), .idx(arrIndex), .wdata(tagWdata), .rdata(tagRdata));

  cvg_array_model #(.IDX_W(IDX_W), .W(DATA_W)) u_dataArr (
    .clk(clk), .we(dataWe), .idx(arrIndex), .wdata(dataWdata), .rdata(dataRdata));

  task automatic cmp(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write; checks the enables in the request cycle and the ack after it.
  task automatic doWrite(input logic sel, input int idx, input logic [DATA_W-1:0] val,
                         input logic xo, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqSel = sel;
    reqIndex = IDX_W'(idx); reqWdata = val; anyXo = xo;
    #1;
    cmp(req, {31'b0, tagWe},  {31'b0, (!sel && !xo)});
    cmp(req, {31'b0, dataWe}, {31'b0, (sel && !xo)});
    if (!xo && !sel) cmp(req, {20'b0, tagWdata}, {20'b0, val[TAG_W-1:0]});
    if (!xo && sel)  cmp(req, dataWdata, val);
    @(posedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0; anyXo = 1'b0;
    @(negedge clk);
    cmp("R8", {31'b0, ackValid}, 32'd1);
  endtask

  // One read; optionally flips anyXo in the response cycle.
  task automatic doRead(input logic sel, input int idx, input logic xo, input bit flip,
                        input logic [DATA_W-1:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSel = sel;
    reqIndex = IDX_W'(idx); reqWdata = '0; anyXo = xo;
    @(posedge clk); #1;
    reqValid = 1'b0;
    anyXo = flip ? !xo : 1'b0;
    @(negedge clk);
    cmp(req, rdData, exp);
    cmp("R8", {31'b0, ackValid}, 32'd1);
    anyXo = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    cmp("R10", {31'b0, ackValid}, 32'd0);
    cmp("R10", {30'b0, tagWe, dataWe}, 32'd0);
    cmp("R10", rdData, 32'd0);
  endtask

  task automatic testOpen();
    doWrite(1'b0, 0, 32'h0000_0ABC, 1'b0, "R1");
    doWrite(1'b1, 15, 32'hDEAD_BEEF, 1'b0, "R2");
    doWrite(1'b1, 7, 32'h5A5A_5A5A, 1'b0, "R2");
    doRead(1'b0, 0, 1'b0, 1'b0, 32'h0000_0ABC, "R3");
    doRead(1'b1, 15, 1'b0, 1'b0, 32'hDEAD_BEEF, "R3");
    doRead(1'b1, 7, 1'b0, 1'b0, 32'h5A5A_5A5A, "R3");
    @(negedge clk);
    cmp("R8", {31'b0, ackValid}, 32'd0);
    cmp("R10", rdData, 32'd0);
  endtask

  task automatic testLocked();
    doWrite(1'b0, 0, 32'h0000_0123, 1'b1, "R4");
    doRead(1'b0, 0, 1'b0, 1'b0, 32'h0000_0ABC, "R4");
    doRead(1'b0, 0, 1'b1, 1'b0, 32'h0000_0ABC, "R5");
    doWrite(1'b1, 15, 32'h1111_1111, 1'b1, "R6");
    doRead(1'b1, 15, 1'b0, 1'b0, 32'hDEAD_BEEF, "R6");
    doRead(1'b1, 15, 1'b1, 1'b0, 32'h0, "R7");
    doRead(1'b1, 7, 1'b1, 1'b0, 32'h0, "R7");
  endtask

  task automatic testSampleTime();
    doRead(1'b1, 15, 1'b1, 1'b1, 32'h0, "R9");
    doRead(1'b1, 15, 1'b0, 1'b1, 32'hDEAD_BEEF, "R9");
    doRead(1'b0, 0, 1'b1, 1'b1, 32'h0000_0ABC, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqSel = 1'b0;
    reqIndex = '0; reqWdata = '0; anyXo = 1'b0;
    repeat (3) @(posedge clk);
    testReset();
    #1 rstN = 1'b1;
    testReset();
    testOpen();
    testLocked();
    testSampleTime();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule